// File: doc/BRIEF.md
# Three-Class Router Output Allocator

This block decides, every cycle, which flits move inside a high-radix router that has a shared central buffer beside its crossbar. Three kinds of move are arbitrated together. A flit held at an input can go straight to its output port (the bypass move). A flit waiting in the central buffer can leave it toward an output port (the drain move). A flit at an input whose output port is taken can be parked in the central buffer instead (the park move). The central buffer has one write port and one read port, so at most one park and one drain happen per cycle.

Priority between the classes is fixed. A drain beats a bypass for the same output port, and a bypass beats a park for the same input flit. Within a class, ties go round-robin. Paths are reserved per packet. When a head flit wins an output port, or wins the central-buffer write port, every later flit of that packet uses the same resource until its tail flit has been granted. The grants are combinational from the current request inputs and the registered lock state. The datapath, route computation and link flow control sit outside the block.

Top module: `tri_path_alloc`

## Requirements
- R1: An output port that is free and has a drain request with the head marker set (cb_head) in the cycle the read port picks it gives no bypass grant that cycle. A head flit aimed at that port is treated as blocked.
- R2: Per cycle, each output port grants at most one input, at most one drain grant and at most one park grant are issued, and no input receives both a bypass and a park grant.
- R3: A valid head flit on an idle input whose destination port (in_dest, binary port index) is free and not claimed by a drain receives the bypass grant for that port. Among several such flits, round-robin picks one.
- R4: A valid head flit on an idle input that wins no bypass grant receives the park grant only when the write port is not reserved and cb_free is at least PKT_FLITS. Otherwise it receives no grant.
- R5: After a bypass grant to a flit without the tail marker, that output port grants only the same input until a tail flit from it is granted. The in_dest field of these later flits is ignored.
- R6: After a park grant to a flit without the tail marker, the write port grants only the same input until its tail flit is granted.
- R7: After a drain grant without the tail marker on port j, port j gives no bypass grant and keeps draining until the drain tail is granted.
- R8: Round-robin among inputs for each output port starts at input 0 after reset. The pointer moves to the input after the winner only when a head flit is granted that port.
- R9: Round-robin among inputs for the park port starts at input 0 after reset. The pointer moves to the input after the winner only when a head flit is parked.
- R10: Round-robin among output ports for the drain port starts at port 0 after reset. The pointer moves to the port after the winner on every drain grant.
- R11: After reset every output port is free, and no input, port or write port is reserved.
- R12: A flit without the head marker from an input holding no reservation receives no grant.
- R13: A flit carrying both the head and the tail marker is granted without leaving any reservation behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | A flit is present at each input |
| in_head | input | N_IN | Head marker of each input flit |
| in_tail | input | N_IN | Tail marker of each input flit |
| in_dest | input | N_IN x OUT_W | Binary destination output port of each input flit |
| cb_req | input | N_OUT | Central buffer holds a flit for each output port |
| cb_head | input | N_OUT | Head marker of the buffered flit per output port |
| cb_tail | input | N_OUT | Tail marker of the buffered flit per output port |
| cb_free | input | FREE_W | Free flit slots in the central buffer |
| byp_gnt | output | N_OUT x N_IN | Bypass grant, one-hot over inputs per output port |
| cbo_gnt | output | N_OUT | Drain grant, at most one bit set |
| cbw_gnt | output | N_IN | Park grant, at most one bit set |

## Verification
The bench builds the block with three inputs and three output ports, so every round-robin pointer has to wrap over a non-power-of-two range. PKT_FLITS is 2 and CB_DEPTH is 4, which puts the park space limit one step away in both directions. With these sizes a full sweep is practical. After a fresh reset it drives every mix of head flits over all destinations, with and without one drain claim, at free space just below and at the limit, and computes the winners by lowest index. Directed sequences then step through pointer rotation, stalled pointers and packet reservations on all three resources.

// File: rtl/tri_path_alloc_pkg.sv
package tri_path_alloc_pkg;

    // Who currently holds an output port.
    typedef enum logic [1:0] {
        OWN_FREE = 2'd0,
        OWN_IN   = 2'd1,
        OWN_CB   = 2'd2
    } own_e;

    // Which resource an input's current packet is bound to.
    typedef enum logic [1:0] {
        PTH_IDLE = 2'd0,
        PTH_OUT  = 2'd1,
        PTH_CB   = 2'd2
    } path_e;

endpackage

// File: rtl/tpa_rr_pick.sv
// Round-robin selector: the first requester at or after the pointer wins.
module tpa_rr_pick #(
    parameter int W    = 4,
    parameter int IW   = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [W-1:0]  gnt
);

    int   slot;
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        slot  = 0;
        for (int k = 0; k < W; k++) begin
            slot = (int'(ptr) + k) % W;
            if (!taken && req[slot]) begin
                gnt[slot] = 1'b1;
                taken     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tpa_oh_index.sv
// One-hot to binary index (zero when no bit is set).
module tpa_oh_index #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  oh,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int k = 0; k < W; k++) begin
            if (oh[k]) idx = idx | IW'(k);
        end
    end

endmodule

// File: rtl/tri_path_alloc.sv
module tri_path_alloc
    import tri_path_alloc_pkg::*;
#(
    parameter int N_IN      = 4,
    parameter int N_OUT     = 4,
    parameter int PKT_FLITS = 4,
    parameter int CB_DEPTH  = 16,
    localparam int IN_W     = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int OUT_W    = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int FREE_W   = $clog2(CB_DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_IN-1:0]                  in_valid,
    input  logic [N_IN-1:0]                  in_head,
    input  logic [N_IN-1:0]                  in_tail,
    input  logic [N_IN-1:0][OUT_W-1:0]       in_dest,
    input  logic [N_OUT-1:0]                 cb_req,
    input  logic [N_OUT-1:0]                 cb_head,
    input  logic [N_OUT-1:0]                 cb_tail,
    input  logic [FREE_W-1:0]                cb_free,
    output logic [N_OUT-1:0][N_IN-1:0]       byp_gnt,
    output logic [N_OUT-1:0]                 cbo_gnt,
    output logic [N_IN-1:0]                  cbw_gnt
);

    // Registered allocation state.
    typedef struct packed {
        own_e  [N_OUT-1:0]            own;
        logic  [N_OUT-1:0][IN_W-1:0]  own_in;
        path_e [N_IN-1:0]             path;
        logic  [N_OUT-1:0][IN_W-1:0]  rr_out;
        logic  [OUT_W-1:0]            rr_cbo;
        logic  [IN_W-1:0]             rr_cbw;
    } alloc_st_t;

    alloc_st_t st_d, st_q;

    logic [N_OUT-1:0]            cbo_req;
    logic [N_OUT-1:0]            cbo_win;
    logic [OUT_W-1:0]            cbo_idx;
    logic [N_OUT-1:0][N_IN-1:0]  byp_req;
    logic [N_OUT-1:0][N_IN-1:0]  byp_win;
    logic [N_OUT-1:0][IN_W-1:0]  byp_idx;
    logic [N_IN-1:0]             in_byp;
    logic [N_IN-1:0]             cbw_req;
    logic [N_IN-1:0]             cbw_win;
    logic [IN_W-1:0]             cbw_idx;
    logic                        cbw_busy;
    logic                        room_ok;

    // ------------------------------------------------------------------
    // Drain side: central buffer to output ports, one grant per cycle.
    // A locked port drains any flit; a free port needs a head flit.
    // ------------------------------------------------------------------
    always_comb begin
        for (int j = 0; j < N_OUT; j++) begin
            cbo_req[j] = cb_req[j] &&
                         ((st_q.own[j] == OWN_CB) ||
                          ((st_q.own[j] == OWN_FREE) && cb_head[j]));
        end
    end

    tpa_rr_pick #(.W(N_OUT), .IW(OUT_W)) u_cbo_pick (
        .req (cbo_req),
        .ptr (st_q.rr_cbo),
        .gnt (cbo_win)
    );

    tpa_oh_index #(.W(N_OUT), .IW(OUT_W)) u_cbo_idx (
        .oh  (cbo_win),
        .idx (cbo_idx)
    );

    // ------------------------------------------------------------------
    // Bypass side: inputs to output ports, one arbiter per port.
    // A drain grant on the same port removes the port from contention.
    // ------------------------------------------------------------------
    always_comb begin
        for (int j = 0; j < N_OUT; j++) begin
            for (int i = 0; i < N_IN; i++) begin
                byp_req[j][i] = 1'b0;
                if (in_valid[i]) begin
                    case (st_q.own[j])
                        OWN_IN:   byp_req[j][i] = (st_q.own_in[j] == IN_W'(i)) &&
                                                  (st_q.path[i] == PTH_OUT);
                        OWN_FREE: byp_req[j][i] = !cbo_win[j] &&
                                                  (st_q.path[i] == PTH_IDLE) &&
                                                  in_head[i] &&
                                                  (in_dest[i] == OUT_W'(j));
                        default:  byp_req[j][i] = 1'b0;
                    endcase
                end
            end
        end
    end

    for (genvar gj = 0; gj < N_OUT; gj++) begin : g_port
        tpa_rr_pick #(.W(N_IN), .IW(IN_W)) u_byp_pick (
            .req (byp_req[gj]),
            .ptr (st_q.rr_out[gj]),
            .gnt (byp_win[gj])
        );

        tpa_oh_index #(.W(N_IN), .IW(IN_W)) u_byp_idx (
            .oh  (byp_win[gj]),
            .idx (byp_idx[gj])
        );
    end

    // ------------------------------------------------------------------
    // Park side: inputs into the central buffer, single write port.
    // A reserved write port serves only its owner; a new head needs room
    // for a whole packet and must have lost the bypass.
    // ------------------------------------------------------------------
    always_comb begin
        cbw_busy = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (st_q.path[i] == PTH_CB) cbw_busy = 1'b1;
        end
        room_ok = (cb_free >= FREE_W'(PKT_FLITS));
        for (int i = 0; i < N_IN; i++) begin
            in_byp[i] = 1'b0;
            for (int j = 0; j < N_OUT; j++) begin
                in_byp[i] = in_byp[i] | byp_win[j][i];
            end
        end
        for (int i = 0; i < N_IN; i++) begin
            cbw_req[i] = in_valid[i] && !in_byp[i] &&
                         ((st_q.path[i] == PTH_CB) ||
                          (!cbw_busy && (st_q.path[i] == PTH_IDLE) &&
                           in_head[i] && room_ok));
        end
    end

    tpa_rr_pick #(.W(N_IN), .IW(IN_W)) u_cbw_pick (
        .req (cbw_req),
        .ptr (st_q.rr_cbw),
        .gnt (cbw_win)
    );

    tpa_oh_index #(.W(N_IN), .IW(IN_W)) u_cbw_idx (
        .oh  (cbw_win),
        .idx (cbw_idx)
    );

    // ------------------------------------------------------------------
    // Next state: locks follow head/tail markers, pointers follow winners.
    // ------------------------------------------------------------------
    always_comb begin
        st_d = st_q;

        if (|cbo_win) begin
            st_d.rr_cbo = (cbo_idx == OUT_W'(N_OUT - 1)) ? '0 : cbo_idx + 1'b1;
        end
        for (int j = 0; j < N_OUT; j++) begin
            if (cbo_win[j]) begin
                st_d.own[j] = cb_tail[j] ? OWN_FREE : OWN_CB;
            end
        end

        for (int j = 0; j < N_OUT; j++) begin
            if (|byp_win[j]) begin
                if (st_q.own[j] == OWN_FREE) begin
                    st_d.rr_out[j] = (byp_idx[j] == IN_W'(N_IN - 1)) ?
                                     '0 : byp_idx[j] + 1'b1;
                end
                st_d.own[j]    = in_tail[byp_idx[j]] ? OWN_FREE : OWN_IN;
                st_d.own_in[j] = byp_idx[j];
                st_d.path[byp_idx[j]] = in_tail[byp_idx[j]] ? PTH_IDLE : PTH_OUT;
            end
        end

        if (|cbw_win) begin
            if (st_q.path[cbw_idx] == PTH_IDLE) begin
                st_d.rr_cbw = (cbw_idx == IN_W'(N_IN - 1)) ? '0 : cbw_idx + 1'b1;
            end
            st_d.path[cbw_idx] = in_tail[cbw_idx] ? PTH_IDLE : PTH_CB;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byp_gnt = byp_win;
    assign cbo_gnt = cbo_win;
    assign cbw_gnt = cbw_win;

endmodule

// File: rtl/tri_path_alloc_chk.sv
module tri_path_alloc_chk #(
    parameter int N_IN      = 4,
    parameter int N_OUT     = 4,
    parameter int PKT_FLITS = 4,
    parameter int CB_DEPTH  = 16,
    localparam int FREE_W   = $clog2(CB_DEPTH + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_IN-1:0]             in_valid,
    input logic [N_IN-1:0]             in_head,
    input logic [N_IN-1:0]             in_tail,
    input logic [N_OUT-1:0]            cb_req,
    input logic [N_OUT-1:0]            cb_tail,
    input logic [FREE_W-1:0]           cb_free,
    input logic [N_OUT-1:0][N_IN-1:0]  byp_gnt,
    input logic [N_OUT-1:0]            cbo_gnt,
    input logic [N_IN-1:0]             cbw_gnt
);

    logic [N_IN-1:0] byp_any;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            byp_any[i] = 1'b0;
            for (int j = 0; j < N_OUT; j++) byp_any[i] = byp_any[i] | byp_gnt[j][i];
        end
    end

    AST_CBO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cbo_gnt)); // R2
    AST_CBW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cbw_gnt)); // R2

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        AST_BYP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(byp_gnt[j])); // R2
        AST_CBO_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) cbo_gnt[j] |-> cb_req[j]); // R10
        AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n) cbo_gnt[j] |-> (byp_gnt[j] == '0)); // R1
        AST_DRAIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (cbo_gnt[j] && !cb_tail[j]) |=> (byp_gnt[j] == '0)); // R7
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            AST_PORT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
                (byp_gnt[j][i] && !in_tail[i]) |=> ((byp_gnt[j] & ~(N_IN'(1) << i)) == '0)); // R5
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_src
        AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n) !(cbw_gnt[i] && byp_any[i])); // R2
        AST_GNT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            (cbw_gnt[i] || byp_any[i]) |-> in_valid[i]); // R12
        AST_PARK_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
            (cbw_gnt[i] && in_head[i]) |-> (cb_free >= FREE_W'(PKT_FLITS))); // R4
        AST_PARK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (cbw_gnt[i] && !in_tail[i]) |=> ((cbw_gnt & ~(N_IN'(1) << i)) == '0)); // R6
    end

endmodule

bind tri_path_alloc tri_path_alloc_chk #(
    .N_IN      (N_IN),
    .N_OUT     (N_OUT),
    .PKT_FLITS (PKT_FLITS),
    .CB_DEPTH  (CB_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_head  (in_head),
    .in_tail  (in_tail),
    .cb_req   (cb_req),
    .cb_tail  (cb_tail),
    .cb_free  (cb_free),
    .byp_gnt  (byp_gnt),
    .cbo_gnt  (cbo_gnt),
    .cbw_gnt  (cbw_gnt)
);

// File: tb/tb_tri_path_alloc.sv
`timescale 1ns/1ps
module tb_tri_path_alloc;

    localparam int NI    = 3;
    localparam int NO    = 3;
    localparam int PKT   = 2;
    localparam int DEPTH = 4;
    localparam int OW    = 2;
    localparam int FW    = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NI-1:0]           in_valid, in_head, in_tail;
    logic [NI-1:0][OW-1:0]   in_dest;
    logic [NO-1:0]           cb_req, cb_head, cb_tail;
    logic [FW-1:0]           cb_free;
    logic [NO-1:0][NI-1:0]   byp_gnt;
    logic [NO-1:0]           cbo_gnt;
    logic [NI-1:0]           cbw_gnt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [FW-1:0] room_lvl = FW'(PKT);

    logic [NO-1:0][NI-1:0] xb;
    logic [NO-1:0]         xo;
    logic [NI-1:0]         xw;
    logic [NI-1:0]         won;

    always #5 clk = ~clk;

    tri_path_alloc #(
        .N_IN(NI), .N_OUT(NO), .PKT_FLITS(PKT), .CB_DEPTH(DEPTH)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail), .in_dest(in_dest),
        .cb_req(cb_req), .cb_head(cb_head), .cb_tail(cb_tail), .cb_free(cb_free),
        .byp_gnt(byp_gnt), .cbo_gnt(cbo_gnt), .cbw_gnt(cbw_gnt)
    );

    function automatic logic [NO-1:0][NI-1:0] bg(int j, int i);
        logic [NO-1:0][NI-1:0] v;
        v = '0;
        v[j][i] = 1'b1;
        return v;
    endfunction

    task automatic clear_in();
        in_valid = '0; in_head = '0; in_tail = '0; in_dest = '0;
        cb_req = '0; cb_head = '0; cb_tail = '0; cb_free = room_lvl;
    endtask

    task automatic put(int i, bit h, bit t, int d);
        in_valid[i] = 1'b1; in_head[i] = h; in_tail[i] = t; in_dest[i] = OW'(d);
    endtask

    task automatic put_cb(int j, bit h, bit t);
        cb_req[j] = 1'b1; cb_head[j] = h; cb_tail[j] = t;
    endtask

    task automatic step();
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        room_lvl = FW'(PKT);
        clear_in();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk(string tag, logic [NO-1:0][NI-1:0] eb,
                       logic [NO-1:0] eo, logic [NI-1:0] ew);
        #1;
        total++;
        if (byp_gnt !== eb || cbo_gnt !== eo || cbw_gnt !== ew) begin
            bad++;
            $display("FAIL %s: byp=%b cbo=%b cbw=%b expected byp=%b cbo=%b cbw=%b",
                     tag, byp_gnt, cbo_gnt, cbw_gnt, eb, eo, ew);
        end
    endtask

    initial begin
        clear_in();

        // R11: reset state, every port and the write port free
        do_reset();
        step(); chk("R11 idle after reset", '0, '0, '0);
        step(); put(0,1,1,0); put(1,1,1,1); put(2,1,1,2);
        chk("R11 all ports free", bg(0,0) | bg(1,1) | bg(2,2), '0, '0);

        // R5 R13: bypass packet lock on port 1
        do_reset();
        step(); put(0,1,0,1);                chk("R5 head locks port", bg(1,0), '0, '0);
        step(); put(0,0,0,2); put(1,1,1,1);  chk("R5 body keeps port, dest ignored", bg(1,0), '0, 3'b010);
        step(); put(0,0,1,0); put(2,1,1,1);  chk("R5 tail still owner", bg(1,0), '0, 3'b100);
        step(); put(2,1,1,1);                chk("R5 port free after tail", bg(1,2), '0, '0);
        step(); put(1,1,1,1);                chk("R13 single flit leaves no lock", bg(1,1), '0, '0);

        // R6 R4: write port lock and free space limit
        do_reset();
        step(); put(0,1,0,0); put(1,1,0,0);  chk("R6 head parks and locks", bg(0,0), '0, 3'b010);
        step(); put(0,0,1,0); put(1,0,0,0); put(2,1,1,0);
        chk("R6 other head blocked from write port", bg(0,0), '0, 3'b010);
        step(); put(1,0,1,0); put(2,1,1,0);  chk("R6 tail parks", bg(0,2), '0, 3'b010);
        step(); put(0,1,1,0); put(2,1,1,0);  chk("R6 write port free again", bg(0,0), '0, 3'b100);
        room_lvl = FW'(PKT-1);
        step(); put(0,1,1,0); put(2,1,1,0);  chk("R4 too little room", bg(0,2), '0, '0);

        // R7 R1: drain lock and drain priority
        do_reset();
        step(); put_cb(1,1,0);                 chk("R7 drain head", '0, 3'b010, '0);
        step(); put_cb(1,0,0); put(0,1,1,1);   chk("R7 drain body holds port", '0, 3'b010, 3'b001);
        step(); put_cb(1,0,1); put(0,1,1,1);   chk("R7 drain tail holds port", '0, 3'b010, 3'b001);
        step(); put(0,1,1,1);                  chk("R7 port free after drain", bg(1,0), '0, '0);
        step(); put_cb(2,1,1); put(1,1,1,2);   chk("R1 drain beats bypass", '0, 3'b100, 3'b010);

        // R8: bypass rotation, pointer stalls without a grant
        do_reset();
        room_lvl = FW'(PKT-1);
        step(); put(0,1,1,0); put(1,1,1,0); put(2,1,1,0); chk("R8 first winner", bg(0,0), '0, '0);
        step(); put(0,1,1,0); put(1,1,1,0); put(2,1,1,0); chk("R8 second winner", bg(0,1), '0, '0);
        step(); put(0,1,1,0); put(1,1,1,0); put(2,1,1,0); put_cb(0,1,1);
        chk("R8 R1 drain takes port", '0, 3'b001, '0);
        step(); put(0,1,1,0); put(1,1,1,0); put(2,1,1,0); chk("R8 pointer held", bg(0,2), '0, '0);
        step(); put(0,1,1,0); put(1,1,1,0); put(2,1,1,0); chk("R8 wrap", bg(0,0), '0, '0);

        // R9: park rotation
        do_reset();
        step(); put(0,1,1,0); put(1,1,1,0); put(2,1,1,0); chk("R9 park 1", bg(0,0), '0, 3'b010);
        step(); put(0,1,1,0); put(1,1,1,0); put(2,1,1,0); chk("R9 park 2", bg(0,1), '0, 3'b100);
        step(); put(0,1,1,0); put(1,1,1,0); put(2,1,1,0); chk("R9 park wrap", bg(0,2), '0, 3'b001);

        // R10: drain rotation
        do_reset();
        step(); put_cb(0,1,1); put_cb(1,1,1); put_cb(2,1,1); chk("R10 drain 0", '0, 3'b001, '0);
        step(); put_cb(0,1,1); put_cb(1,1,1); put_cb(2,1,1); chk("R10 drain 1", '0, 3'b010, '0);
        step(); put_cb(0,1,1); put_cb(1,1,1); put_cb(2,1,1); chk("R10 drain 2", '0, 3'b100, '0);
        step(); put_cb(0,1,1); put_cb(1,1,1); put_cb(2,1,1); chk("R10 drain wrap", '0, 3'b001, '0);

        // R12: body flits without a reservation
        do_reset();
        step(); put(0,0,0,1); put(1,0,1,2); put(2,0,0,0); chk("R12 stray body ignored", '0, '0, '0);
        step(); put(2,1,1,0); chk("R12 state untouched", bg(0,2), '0, '0);

        // R1 R2 R3 R4: sweep of all head mixes from a fresh reset
        for (int p = 0; p < 64; p++) begin
            for (int c = 0; c <= NO; c++) begin
                for (int r = 0; r < 2; r++) begin
                    do_reset();
                    room_lvl = (r == 1) ? FW'(PKT) : FW'(PKT-1);
                    step();
                    xb = '0; xo = '0; xw = '0; won = '0;
                    for (int i = 0; i < NI; i++) begin
                        if (((p >> (2*i)) & 3) != 0) put(i, 1'b1, 1'b1, ((p >> (2*i)) & 3) - 1);
                    end
                    if (c < NO) begin
                        put_cb(c, 1'b1, 1'b1);
                        xo[c] = 1'b1;
                    end
                    for (int j = 0; j < NO; j++) begin
                        for (int i = 0; i < NI; i++) begin
                            if (j != c && ((p >> (2*i)) & 3) == j + 1 && xb[j] == '0) begin
                                xb[j][i] = 1'b1;
                                won[i] = 1'b1;
                            end
                        end
                    end
                    for (int i = 0; i < NI; i++) begin
                        if (((p >> (2*i)) & 3) != 0 && !won[i] && xw == '0 && r == 1) xw[i] = 1'b1;
                    end
                    chk("R1 R2 R3 R4 sweep", xb, xo, xw);
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule